// File: doc/BRIEF.md
# Variable-Length Instruction Operand Decoder

This block consumes a byte stream holding variable-length instructions and decodes one instruction at a time. Each instruction opens with a two-byte header giving the operand size, the opcode number, a pointer-offset enable, a condition code and the addressing kind of both operands. The header is followed by the source operand bytes, an optional source offset byte, the destination operand bytes and an optional destination offset byte. The number of bytes that follow the header depends on the size field, on each operand's addressing kind, on the offset enable and on a class input. That input marks shift, rotate and bit-manipulation opcodes, whose source immediate is always one byte.

Bytes enter through a valid/ready interface. A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The sender must hold `in_byte` steady while `in_valid` is high and `in_ready` is low. Gaps in `in_valid` are allowed at any point. `in_ready` drops for exactly one cycle, the cycle in which `done` is reported. Nothing is taken in that cycle. The decoded fields, operand values, offsets and total length are plain outputs, valid while `done` is high. They keep their values until the next byte is taken.

Top module: `vlen_opdec`

## Requirements
- R1: The header arrives low byte first. In the first byte, bit 7 is the offset enable, bits 6:4 are the condition, bits 3:2 are the destination kind and bits 1:0 are the source kind. In the second byte, bits 7:6 are the size and bits 5:0 are the opcode. All of these appear on their own output pins.
- R2: Operand kinds 2 (immediate) and 3 (immediate pointer) carry 1, 2 or 4 bytes for size codes 0, 1 and 2. The bytes are in little-endian order and are zero-extended into the operand value.
- R3: Operand kinds 0 (register) and 1 (register pointer) carry one byte, the register number. It is zero-extended into the operand value.
- R4: When the offset enable is 1, each kind-1 operand is followed by one offset byte, output sign-extended to 32 bits on that operand's offset pin. Every other offset pin reads zero, and the enable adds no bytes to operands of other kinds.
- R5: If `narrow_src` is high when the second header byte is taken, a kind-2 source immediate is one byte whatever the size. The destination operand and a kind-3 source keep the width given by the size.
- R6: After the header come the source bytes, then the source offset byte if present, then the destination bytes, then the destination offset byte if present.
- R7: `done` is high for one cycle, the cycle after the last byte of an instruction is taken. `len` then gives the instruction's total byte count. All outputs hold their values while no byte is taken.
- R8: `in_ready` is low during the `done` cycle and high at all other times after reset. A byte offered during the `done` cycle is not taken, and the next header is taken from the following cycle on.
- R9: Size code 3 is illegal. The cycle after the second header byte is taken, `done` and `illegal` are both high and `len` is 2. No operand bytes are taken, so the next byte starts a new header.
- R10: During and after reset, `done` and `illegal` are low, `in_ready` is high and `len` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_byte | input | 8 | Instruction byte |
| narrow_src | input | 1 | Opcode belongs to the shift/rotate/bit class; sampled with the second header byte |
| done | output | 1 | One-cycle decode-complete pulse |
| illegal | output | 1 | Reserved size seen; high together with done |
| len | output | 4 | Total instruction length in bytes |
| op_size | output | 2 | Size code |
| op_code | output | 6 | Opcode number |
| ptr_off_en | output | 1 | Offset enable |
| cond | output | 3 | Condition code |
| dst_kind | output | 2 | Destination addressing kind |
| src_kind | output | 2 | Source addressing kind |
| src_val | output | 32 | Source register number or immediate |
| dst_val | output | 32 | Destination register number or immediate |
| src_disp | output | 32 | Sign-extended source pointer offset |
| dst_disp | output | 32 | Sign-extended destination pointer offset |

## Verification
The hardest case is an instruction whose layout changes partway through. Examples are a narrowed source immediate followed by a full-width destination, and an offset byte placed after one operand but not the other. In these cases a wrong byte count only shows up as shifted values several bytes later. The stimulus builds mixed-kind instructions with the offset enable set and negative offsets, and narrowed sources under size 2. It then checks every operand and offset value as well as the length. A reserved-size header, and a byte offered during the done cycle, are each followed straight away by a normal instruction. This shows that no stray byte was taken.

// File: rtl/vlen_opdec_pkg.sv
package vlen_opdec_pkg;

  typedef enum logic [2:0] {
    PH_HDR0 = 3'd0,
    PH_HDR1 = 3'd1,
    PH_SRC  = 3'd2,
    PH_SOFF = 3'd3,
    PH_DST  = 3'd4,
    PH_DOFF = 3'd5,
    PH_FIN  = 3'd6
  } phase_e;

  localparam logic [1:0] KIND_REG  = 2'd0;
  localparam logic [1:0] KIND_RPTR = 2'd1;
  localparam logic [1:0] KIND_IMM  = 2'd2;
  localparam logic [1:0] KIND_IPTR = 2'd3;

  localparam logic [1:0] SIZE_RSVD = 2'd3;

  // Packed so that {second byte, first byte} maps straight onto it.
  typedef struct packed {
    logic [1:0] size;
    logic [5:0] opc;
    logic       offen;
    logic [2:0] cond;
    logic [1:0] dkind;
    logic [1:0] skind;
  } hdr_t;

endpackage

// File: rtl/vlen_opdec_layout.sv
module vlen_opdec_layout
  import vlen_opdec_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int CNT_W = 3,
  parameter int LEN_W = 4
) (
  input  hdr_t                      hdr,
  input  logic                      narrow,
  output logic [1:0][CNT_W-1:0]     body_len,
  output logic [1:0][CNT_W-1:0]     tail_len,
  output logic [LEN_W-1:0]          total
);

  localparam int OPB = OPW / 8;

  logic [CNT_W-1:0] imm_full;

  always_comb begin
    if (hdr.size == SIZE_RSVD) imm_full = CNT_W'(1);
    else                       imm_full = CNT_W'(1) << hdr.size;
    if (int'(imm_full) > OPB)  imm_full = CNT_W'(OPB);
  end

  // Operand 0 is the source, operand 1 the destination.
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [1:0] kind;
    logic       force1;
    assign kind   = (g == 0) ? hdr.skind : hdr.dkind;
    assign force1 = (g == 0) && narrow;

    always_comb begin
      unique case (kind)
        KIND_REG,
        KIND_RPTR: body_len[g] = CNT_W'(1);
        KIND_IMM:  body_len[g] = force1 ? CNT_W'(1) : imm_full;
        default:   body_len[g] = imm_full;
      endcase
      tail_len[g] = (hdr.offen && kind == KIND_RPTR) ? CNT_W'(1) : CNT_W'(0);
    end
  end

  assign total = LEN_W'(2)
               + LEN_W'(body_len[0]) + LEN_W'(tail_len[0])
               + LEN_W'(body_len[1]) + LEN_W'(tail_len[1]);

endmodule

// File: rtl/vlen_opdec_seq.sv
module vlen_opdec_seq
  import vlen_opdec_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  rsvd_size,
  input  logic [1:0][CNT_W-1:0] body_len,
  input  logic [1:0][CNT_W-1:0] tail_len,
  output logic                  in_ready,
  output logic                  fin,
  output logic [1:0]            hdr_we,
  output logic [1:0]            body_we,
  output logic [1:0]            tail_we,
  output logic [IDX_W-1:0]      idx,
  output logic                  fin_enter,
  output logic                  rsvd_hit
);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             acc;
  logic             src_last, dst_last;

  assign in_ready = (phase_q != PH_FIN);
  assign fin      = (phase_q == PH_FIN);
  assign acc      = in_valid && in_ready;
  assign idx      = idx_q;

  assign src_last = ({1'b0, idx_q} == CNT_W'(body_len[0] - CNT_W'(1)));
  assign dst_last = ({1'b0, idx_q} == CNT_W'(body_len[1] - CNT_W'(1)));

  assign hdr_we[0]  = acc && (phase_q == PH_HDR0);
  assign hdr_we[1]  = acc && (phase_q == PH_HDR1);
  assign body_we[0] = acc && (phase_q == PH_SRC);
  assign body_we[1] = acc && (phase_q == PH_DST);
  assign tail_we[0] = acc && (phase_q == PH_SOFF);
  assign tail_we[1] = acc && (phase_q == PH_DOFF);
  assign rsvd_hit   = hdr_we[1] && rsvd_size;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_HDR0: if (acc) phase_d = PH_HDR1;
      PH_HDR1: if (acc) begin
        phase_d = rsvd_size ? PH_FIN : PH_SRC;
        idx_d   = '0;
      end
      PH_SRC: if (acc) begin
        if (src_last) begin
          phase_d = (tail_len[0] != '0) ? PH_SOFF : PH_DST;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      PH_SOFF: if (acc) phase_d = PH_DST;
      PH_DST: if (acc) begin
        if (dst_last) begin
          phase_d = (tail_len[1] != '0) ? PH_DOFF : PH_FIN;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      PH_DOFF: if (acc) phase_d = PH_FIN;
      default: phase_d = PH_HDR0;
    endcase
  end

  assign fin_enter = (phase_d == PH_FIN) && (phase_q != PH_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HDR0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/vlen_opdec_operand.sv
module vlen_opdec_operand #(
  parameter int OPW   = 32,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             body_we,
  input  logic [IDX_W-1:0] idx,
  input  logic             tail_we,
  input  logic [7:0]       din,
  output logic [OPW-1:0]   val,
  output logic [OPW-1:0]   disp
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      val  <= '0;
      disp <= '0;
    end else begin
      if (body_we) val[8*int'(idx) +: 8] <= din;
      if (tail_we) disp <= {{(OPW-8){din[7]}}, din};
    end
  end

endmodule

// File: rtl/vlen_opdec.sv
module vlen_opdec
  import vlen_opdec_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_byte,
  input  logic           narrow_src,
  output logic           done,
  output logic           illegal,
  output logic [3:0]     len,
  output logic [1:0]     op_size,
  output logic [5:0]     op_code,
  output logic           ptr_off_en,
  output logic [2:0]     cond,
  output logic [1:0]     dst_kind,
  output logic [1:0]     src_kind,
  output logic [OPW-1:0] src_val,
  output logic [OPW-1:0] dst_val,
  output logic [OPW-1:0] src_disp,
  output logic [OPW-1:0] dst_disp
);

  localparam int OPB   = OPW / 8;
  localparam int IDX_W = $clog2(OPB);
  localparam int CNT_W = IDX_W + 1;
  localparam int LEN_W = 4;

  hdr_t                  hdr_q;
  logic                  narrow_q;
  logic                  bad_q;
  logic [LEN_W-1:0]      len_q;
  logic [1:0][CNT_W-1:0] body_len, tail_len;
  logic [LEN_W-1:0]      total;
  logic [1:0]            hdr_we, body_we, tail_we;
  logic [IDX_W-1:0]      idx;
  logic                  fin, fin_enter, rsvd_hit;
  logic [1:0][OPW-1:0]   vals, disps;

  vlen_opdec_layout #(.OPW(OPW), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_layout (
    .hdr      (hdr_q),
    .narrow   (narrow_q),
    .body_len (body_len),
    .tail_len (tail_len),
    .total    (total)
  );

  vlen_opdec_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rsvd_size (in_byte[7:6] == SIZE_RSVD),
    .body_len  (body_len),
    .tail_len  (tail_len),
    .in_ready  (in_ready),
    .fin       (fin),
    .hdr_we    (hdr_we),
    .body_we   (body_we),
    .tail_we   (tail_we),
    .idx       (idx),
    .fin_enter (fin_enter),
    .rsvd_hit  (rsvd_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_asm
    vlen_opdec_operand #(.OPW(OPW), .IDX_W(IDX_W)) u_opnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hdr_we[1]),
      .body_we (body_we[g]),
      .idx     (idx),
      .tail_we (tail_we[g]),
      .din     (in_byte),
      .val     (vals[g]),
      .disp    (disps[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      narrow_q <= 1'b0;
      bad_q    <= 1'b0;
      len_q    <= '0;
    end else begin
      if (hdr_we[0]) hdr_q[7:0] <= in_byte;
      if (hdr_we[1]) begin
        hdr_q[15:8] <= in_byte;
        narrow_q    <= narrow_src;
        bad_q       <= rsvd_hit;
      end
      if (fin_enter) len_q <= rsvd_hit ? LEN_W'(2) : total;
    end
  end

  assign done       = fin;
  assign illegal    = fin && bad_q;
  assign len        = len_q;
  assign op_size    = hdr_q.size;
  assign op_code    = hdr_q.opc;
  assign ptr_off_en = hdr_q.offen;
  assign cond       = hdr_q.cond;
  assign dst_kind   = hdr_q.dkind;
  assign src_kind   = hdr_q.skind;
  assign src_val    = vals[0];
  assign dst_val    = vals[1];
  assign src_disp   = disps[0];
  assign dst_disp   = disps[1];

endmodule

// File: rtl/vlen_opdec_chk.sv
module vlen_opdec_chk #(
  parameter int OPW   = 32,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic             illegal,
  input logic [LEN_W-1:0] len,
  input logic [1:0]       op_size,
  input logic             ptr_off_en,
  input logic [1:0]       dst_kind,
  input logic [1:0]       src_kind,
  input logic [OPW-1:0]   src_val,
  input logic [OPW-1:0]   src_disp,
  input logic [OPW-1:0]   dst_disp
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R8
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  // R9
  illegal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && len == LEN_W'(2) && op_size == 2'd3));

  // R9
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (op_size != 2'd3));

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (len >= LEN_W'(4) && len <= LEN_W'(12)));

  // R4
  src_disp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(ptr_off_en && src_kind == 2'd1)) |-> (src_disp == '0));

  // R4
  dst_disp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(ptr_off_en && dst_kind == 2'd1)) |-> (dst_disp == '0));

  // R4
  disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(src_disp[OPW-1:7]) == 0 ||
              $countones(src_disp[OPW-1:7]) == OPW-7));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(src_val) && $stable(src_disp)));

endmodule

bind vlen_opdec vlen_opdec_chk #(.OPW(OPW), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .illegal    (illegal),
  .len        (len),
  .op_size    (op_size),
  .ptr_off_en (ptr_off_en),
  .dst_kind   (dst_kind),
  .src_kind   (src_kind),
  .src_val    (src_val),
  .src_disp   (src_disp),
  .dst_disp   (dst_disp)
);

// File: tb/test_vlen_opdec.sv
module test_vlen_opdec;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        narrow_src;
  logic        done, illegal;
  logic [3:0]  len;
  logic [1:0]  op_size;
  logic [5:0]  op_code;
  logic        ptr_off_en;
  logic [2:0]  cond;
  logic [1:0]  dst_kind, src_kind;
  logic [31:0] src_val, dst_val, src_disp, dst_disp;

  int total_chk = 0;
  int bad_chk   = 0;
  logic [7:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_opdec i_vlen_opdec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .narrow_src(narrow_src), .done(done), .illegal(illegal),
    .len(len), .op_size(op_size), .op_code(op_code), .ptr_off_en(ptr_off_en),
    .cond(cond), .dst_kind(dst_kind), .src_kind(src_kind), .src_val(src_val),
    .dst_val(dst_val), .src_disp(src_disp), .dst_disp(dst_disp)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total_chk++;
    if (got !== exp) begin
      bad_chk++;
      $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Called at a negedge with in_ready high; returns at the negedge where done shows.
  task automatic send_all(input bit gap);
    for (int i = 0; i < q.size(); i++) begin
      in_valid = 1'b1;
      in_byte  = q[i];
      @(negedge clk);
      if (gap && i + 1 < q.size()) begin
        in_valid = 1'b0;
        in_byte  = 8'hEE;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    q.delete();
  endtask

  task automatic expect_insn(input string req, input int exp_len,
                             input logic [31:0] s, input logic [31:0] d,
                             input logic [31:0] so, input logic [31:0] dof);
    check(req, "done",     32'(done), 32'd1);
    check(req, "illegal",  32'(illegal), 32'd0);
    check(req, "len",      32'(len), 32'(exp_len));
    check(req, "src_val",  src_val, s);
    check(req, "dst_val",  dst_val, d);
    check(req, "src_disp", src_disp, so);
    check(req, "dst_disp", dst_disp, dof);
  endtask

  task automatic next_cycle_idle();
    @(negedge clk);
    check("R7", "done pulse width", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check("R10", "done",     32'(done), 32'd0);
    check("R10", "illegal",  32'(illegal), 32'd0);
    check("R10", "in_ready", 32'(in_ready), 32'd1);
    check("R10", "len",      32'(len), 32'd0);
  endtask

  // R1 R3: header fields, plain register operands
  task automatic t_regs();
    narrow_src = 1'b0;
    q = '{8'h50, 8'hAA, 8'h07, 8'h0C};
    send_all(1'b0);
    expect_insn("R3", 4, 32'h7, 32'hC, 32'h0, 32'h0);
    check("R1", "cond",       32'(cond), 32'd5);
    check("R1", "op_code",    32'(op_code), 32'h2A);
    check("R1", "op_size",    32'(op_size), 32'd2);
    check("R1", "ptr_off_en", 32'(ptr_off_en), 32'd0);
    check("R1", "kinds",      32'({dst_kind, src_kind}), 32'd0);
    next_cycle_idle();
  endtask

  // R2 32-bit immediate; R8 byte offered in the done cycle is refused
  task automatic t_imm32_and_refuse();
    narrow_src = 1'b0;
    q = '{8'h02, 8'h81, 8'h78, 8'h56, 8'h34, 8'h12, 8'h03};
    send_all(1'b0);
    expect_insn("R2", 7, 32'h12345678, 32'h3, 32'h0, 32'h0);
    check("R8", "in_ready in done cycle", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    in_byte  = 8'hFF;
    @(negedge clk);
    check("R8", "in_ready after done", 32'(in_ready), 32'd1);
    q = '{8'h0E, 8'h03, 8'h9F, 8'h44};
    send_all(1'b0);
    expect_insn("R8", 4, 32'h9F, 32'h44, 32'h0, 32'h0);
    check("R1", "kinds size0", 32'({dst_kind, src_kind}), 32'hE);
    next_cycle_idle();
  endtask

  // R2 16-bit immediate pointer and immediate with input gaps; R7 hold
  task automatic t_imm16_gaps();
    narrow_src = 1'b0;
    q = '{8'h0B, 8'h42, 8'hCD, 8'hAB, 8'h34, 8'h12};
    send_all(1'b1);
    expect_insn("R2", 6, 32'hABCD, 32'h1234, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    check("R7", "src_val held", src_val, 32'hABCD);
    check("R7", "len held",     32'(len), 32'd6);
  endtask

  // R4 R6: offset bytes placed after each register-pointer operand
  task automatic t_offsets();
    narrow_src = 1'b0;
    q = '{8'h85, 8'h80, 8'h02, 8'hF0, 8'h05, 8'h10};
    send_all(1'b0);
    expect_insn("R6", 6, 32'h2, 32'h5, 32'hFFFFFFF0, 32'h10);
    next_cycle_idle();
    q = '{8'h88, 8'h40, 8'h01, 8'h22, 8'h11};
    send_all(1'b0);
    expect_insn("R4", 5, 32'h1, 32'h1122, 32'h0, 32'h0);
    next_cycle_idle();
    q = '{8'h86, 8'h00, 8'h55, 8'h09, 8'h80};
    send_all(1'b0);
    expect_insn("R4", 5, 32'h55, 32'h9, 32'h0, 32'hFFFFFF80);
    next_cycle_idle();
  endtask

  // R5: narrowed source immediate
  task automatic t_narrow();
    narrow_src = 1'b1;
    q = '{8'h0A, 8'h80, 8'hAB, 8'h01, 8'h02, 8'h03, 8'h04};
    send_all(1'b0);
    expect_insn("R5", 7, 32'hAB, 32'h04030201, 32'h0, 32'h0);
    next_cycle_idle();
    q = '{8'h0B, 8'h41, 8'h11, 8'h22, 8'h33, 8'h44};
    send_all(1'b0);
    expect_insn("R5", 6, 32'h2211, 32'h4433, 32'h0, 32'h0);
    narrow_src = 1'b0;
    next_cycle_idle();
  endtask

  // R9: reserved size, then a normal instruction follows at once
  task automatic t_illegal();
    narrow_src = 1'b0;
    q = '{8'h0A, 8'hC0};
    send_all(1'b0);
    check("R9", "done",    32'(done), 32'd1);
    check("R9", "illegal", 32'(illegal), 32'd1);
    check("R9", "len",     32'(len), 32'd2);
    @(negedge clk);
    check("R9", "illegal cleared", 32'(illegal), 32'd0);
    q = '{8'h50, 8'hAA, 8'h07, 8'h0C};
    send_all(1'b0);
    expect_insn("R9", 4, 32'h7, 32'hC, 32'h0, 32'h0);
    next_cycle_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad_chk++;
    total_chk++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_byte    = 8'h00;
    narrow_src = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_imm32_and_refuse();
    t_imm16_gaps();
    t_offsets();
    t_narrow();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule